// File: doc/BRIEF.md
# Clock Alarm Match and Interrupt Flag Unit

This block is the interrupt side of a real-time clock. It takes the current seconds, minutes and hours fields and three alarm bytes from the surrounding register file. When the clock core signals that an update has finished, the block compares each time field with its alarm byte. If all three agree, it sets an alarm flag. An alarm byte whose two top bits are both set is a wildcard and agrees with any value, so an alarm can fire every second, every minute or every hour.

Three event flags are collected into one status byte: periodic (bit 6), alarm (bit 5) and update-ended (bit 4). Each flag is set by its event whether or not it is enabled. The summary bit 7 and the `irq_o` output are high while at least one set flag has its enable high. Bits 3..0 always read zero. Reading the status byte returns its present value and clears the flags on the following edge. An event that lands in the same cycle as that read survives the clear.

All pins are plain control and status signals with no data stream. Nothing here uses valid/ready, so there is no back-pressure. Time counting and tick-rate generation happen outside this block.

Top module: `rtc_alarm_irq`

## Requirements
- R1: After reset, `stat_q` is 0x00 and `irq_o` is 0.
- R2: A one-cycle `tick_periodic` pulse sets status bit 6 on the next clock edge, whatever the value of `en_periodic`.
- R3: A one-cycle `update_done` pulse sets status bit 4 on the next clock edge, whatever the value of `en_update`.
- R4: On an `update_done` cycle, status bit 5 is set at the next edge when the seconds, minutes and hours fields each agree with their alarm byte. If any one field disagrees, bit 5 stays as it was. With no `update_done`, the alarm bytes have no effect.
- R5: An alarm byte agrees with its time field when the two bytes are equal, or when the alarm byte has bits 7 and 6 both set. A byte with only bit 7 set is not a wildcard.
- R6: A set flag stays set until a status read.
- R7: A cycle with `stat_rd` high returns the current `stat_q`. At the following edge, bits 6, 5 and 4 clear unless rule R8 applies.
- R8: A flag event that arrives in the same cycle as `stat_rd` leaves that flag set after the clear.
- R9: Status bit 7 and `irq_o` both equal the OR, over the three flags, of each flag ANDed with its enable. A change of enable shows within the same cycle.
- R10: Status bits 3..0 are always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cur_sec | input | FIELD_W | Current seconds |
| cur_min | input | FIELD_W | Current minutes |
| cur_hr | input | FIELD_W | Current hours |
| alm_sec | input | FIELD_W | Seconds alarm byte |
| alm_min | input | FIELD_W | Minutes alarm byte |
| alm_hr | input | FIELD_W | Hours alarm byte |
| tick_periodic | input | 1 | Periodic event pulse |
| update_done | input | 1 | Update-finished pulse, also the alarm compare strobe |
| en_periodic | input | 1 | Enable for the periodic flag |
| en_alarm | input | 1 | Enable for the alarm flag |
| en_update | input | 1 | Enable for the update flag |
| stat_rd | input | 1 | Status read strobe; clears the flags at the next edge |
| stat_q | output | 8 | Status byte {summary, periodic, alarm, update, 4'b0} |
| irq_o | output | 1 | Active-high interrupt |

## Verification
The bench builds the block with its defaults: 8-bit fields and a 2-bit wildcard marker at the top of each alarm byte. These values make the wildcard corner reachable: a byte with only bit 7 set must still compare exactly. They also allow a seconds wildcard to be combined with exact minutes and hours. At this width, a one-field mismatch can be placed in each position in turn. A read can also be made to coincide with a periodic tick to show a same-cycle event surviving the clear.

// File: rtl/rtc_alarm_pkg.sv
package rtc_alarm_pkg;
  localparam int STAT_W  = 8;
  localparam int BIT_SUM = 7;
  localparam int BIT_PF  = 6;
  localparam int BIT_AF  = 5;
  localparam int BIT_UF  = 4;
  localparam int NFIELDS = 3;

  typedef struct packed {
    logic pf;
    logic af;
    logic uf;
  } flags_t;
endpackage

// File: rtl/alarm_field_match.sv
module alarm_field_match #(
  parameter int FIELD_W   = 8,
  parameter int WILD_BITS = 2
) (
  input  logic [FIELD_W-1:0] alarm,
  input  logic [FIELD_W-1:0] cur,
  output logic               hit
);
  localparam int TOP = FIELD_W - 1;

  logic wild;
  assign wild = &alarm[TOP -: WILD_BITS];
  assign hit  = wild || (alarm == cur);
endmodule

// File: rtl/rtc_alarm_match.sv
module rtc_alarm_match #(
  parameter int FIELD_W   = 8,
  parameter int WILD_BITS = 2,
  parameter int NFIELDS   = 3
) (
  input  logic [NFIELDS*FIELD_W-1:0] alarm_vec,
  input  logic [NFIELDS*FIELD_W-1:0] cur_vec,
  output logic                       all_hit
);
  logic [NFIELDS-1:0] hits;

  for (genvar g = 0; g < NFIELDS; g++) begin : g_fld
    alarm_field_match #(
      .FIELD_W  (FIELD_W),
      .WILD_BITS(WILD_BITS)
    ) u_fld (
      .alarm(alarm_vec[g*FIELD_W +: FIELD_W]),
      .cur  (cur_vec[g*FIELD_W +: FIELD_W]),
      .hit  (hits[g])
    );
  end

  assign all_hit = &hits;
endmodule

// File: rtl/irq_flag_reg.sv
module irq_flag_reg
  import rtc_alarm_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  flags_t set_ev,
  input  flags_t enables,
  input  logic   rd_clr,
  output flags_t flags_q,
  output logic   summary
);
  flags_t flags_d;

  always_comb begin
    flags_d = (rd_clr ? '0 : flags_q) | set_ev;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) flags_q <= '0;
    else        flags_q <= flags_d;
  end

  assign summary = |(flags_q & enables);
endmodule

// File: rtl/rtc_alarm_irq.sv
module rtc_alarm_irq
  import rtc_alarm_pkg::*;
#(
  parameter int FIELD_W   = 8,
  parameter int WILD_BITS = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [FIELD_W-1:0] cur_sec,
  input  logic [FIELD_W-1:0] cur_min,
  input  logic [FIELD_W-1:0] cur_hr,
  input  logic [FIELD_W-1:0] alm_sec,
  input  logic [FIELD_W-1:0] alm_min,
  input  logic [FIELD_W-1:0] alm_hr,
  input  logic               tick_periodic,
  input  logic               update_done,
  input  logic               en_periodic,
  input  logic               en_alarm,
  input  logic               en_update,
  input  logic               stat_rd,
  output logic [STAT_W-1:0]  stat_q,
  output logic               irq_o
);
  localparam int VEC_W = NFIELDS * FIELD_W;

  logic [VEC_W-1:0] alarm_vec;
  logic [VEC_W-1:0] cur_vec;
  logic             time_hit;
  flags_t           set_ev;
  flags_t           enables;
  flags_t           flags_q;
  logic             summary;

  assign alarm_vec = {alm_hr, alm_min, alm_sec};
  assign cur_vec   = {cur_hr, cur_min, cur_sec};

  rtc_alarm_match #(
    .FIELD_W  (FIELD_W),
    .WILD_BITS(WILD_BITS),
    .NFIELDS  (NFIELDS)
  ) u_match (
    .alarm_vec(alarm_vec),
    .cur_vec  (cur_vec),
    .all_hit  (time_hit)
  );

  always_comb begin
    set_ev.pf  = tick_periodic;
    set_ev.af  = update_done && time_hit;
    set_ev.uf  = update_done;
    enables.pf = en_periodic;
    enables.af = en_alarm;
    enables.uf = en_update;
  end

  irq_flag_reg u_flags (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_ev (set_ev),
    .enables(enables),
    .rd_clr (stat_rd),
    .flags_q(flags_q),
    .summary(summary)
  );

  always_comb begin
    stat_q          = '0;
    stat_q[BIT_SUM] = summary;
    stat_q[BIT_PF]  = flags_q.pf;
    stat_q[BIT_AF]  = flags_q.af;
    stat_q[BIT_UF]  = flags_q.uf;
  end

  assign irq_o = summary;
endmodule

// File: rtl/rtc_alarm_irq_chk.sv
module rtc_alarm_irq_chk #(
  parameter int FIELD_W   = 8,
  parameter int WILD_BITS = 2
) (
  input logic               clk,
  input logic               rst_n,
  input logic [FIELD_W-1:0] cur_sec,
  input logic [FIELD_W-1:0] cur_min,
  input logic [FIELD_W-1:0] cur_hr,
  input logic [FIELD_W-1:0] alm_sec,
  input logic [FIELD_W-1:0] alm_min,
  input logic [FIELD_W-1:0] alm_hr,
  input logic               tick_periodic,
  input logic               update_done,
  input logic               en_periodic,
  input logic               en_alarm,
  input logic               en_update,
  input logic               stat_rd,
  input logic [7:0]         stat_q,
  input logic               irq_o
);
  localparam int TOP = FIELD_W - 1;

  logic ok_s, ok_m, ok_h;
  assign ok_s = (alm_sec[TOP -: WILD_BITS] == '1) || (alm_sec == cur_sec);
  assign ok_m = (alm_min[TOP -: WILD_BITS] == '1) || (alm_min == cur_min);
  assign ok_h = (alm_hr[TOP -: WILD_BITS]  == '1) || (alm_hr  == cur_hr);

  a_r2_pf_set: assert property (@(posedge clk) disable iff (!rst_n)
    tick_periodic |=> stat_q[6]);

  a_r3_uf_set: assert property (@(posedge clk) disable iff (!rst_n)
    update_done |=> stat_q[4]);

  a_r4_af_set: assert property (@(posedge clk) disable iff (!rst_n)
    (update_done && ok_s && ok_m && ok_h) |=> stat_q[5]);

  a_r4_af_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!stat_q[5] && !(update_done && ok_s && ok_m && ok_h)) |=> !stat_q[5]);

  a_r6_hold_flags: assert property (@(posedge clk) disable iff (!rst_n)
    !stat_rd |=> ((stat_q[6:4] & $past(stat_q[6:4])) == $past(stat_q[6:4])));

  a_r7_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && !tick_periodic && !update_done) |=> (stat_q[7:4] == 4'b0));

  a_r9_irq_pin: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o == stat_q[7]);

  a_r9_summary: assert property (@(posedge clk) disable iff (!rst_n)
    stat_q[7] == ((stat_q[6] && en_periodic) || (stat_q[5] && en_alarm) ||
                  (stat_q[4] && en_update)));

  a_r10_low_zero: assert property (@(posedge clk) disable iff (!rst_n)
    stat_q[3:0] == 4'b0);
endmodule

bind rtc_alarm_irq rtc_alarm_irq_chk #(
  .FIELD_W  (FIELD_W),
  .WILD_BITS(WILD_BITS)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .cur_sec      (cur_sec),
  .cur_min      (cur_min),
  .cur_hr       (cur_hr),
  .alm_sec      (alm_sec),
  .alm_min      (alm_min),
  .alm_hr       (alm_hr),
  .tick_periodic(tick_periodic),
  .update_done  (update_done),
  .en_periodic  (en_periodic),
  .en_alarm     (en_alarm),
  .en_update    (en_update),
  .stat_rd      (stat_rd),
  .stat_q       (stat_q),
  .irq_o        (irq_o)
);

// File: tb/rtc_alarm_irq_bench.sv
module rtc_alarm_irq_bench;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] cur_sec = '0, cur_min = '0, cur_hr = '0;
  logic [7:0] alm_sec = '0, alm_min = '0, alm_hr = '0;
  logic       tick_periodic = 1'b0, update_done = 1'b0;
  logic       en_periodic = 1'b0, en_alarm = 1'b0, en_update = 1'b0;
  logic       stat_rd = 1'b0;
  logic [7:0] stat_q;
  logic       irq_o;

  always #(CLK_PERIOD/2) clk = ~clk;

  rtc_alarm_irq u_rtc_alarm_irq (
    .clk(clk), .rst_n(rst_n),
    .cur_sec(cur_sec), .cur_min(cur_min), .cur_hr(cur_hr),
    .alm_sec(alm_sec), .alm_min(alm_min), .alm_hr(alm_hr),
    .tick_periodic(tick_periodic), .update_done(update_done),
    .en_periodic(en_periodic), .en_alarm(en_alarm), .en_update(en_update),
    .stat_rd(stat_rd), .stat_q(stat_q), .irq_o(irq_o)
  );

  typedef struct {
    logic [7:0] st;
    logic       irq;
    string      req;
  } exp_t;

  exp_t exp_q[$];
  int   checks = 0;
  int   errors = 0;
  bit   done = 0;
  logic m_pf = 0, m_af = 0, m_uf = 0;

  function automatic bit fld_ok(input logic [7:0] a, input logic [7:0] c);
    return (a[7:6] == 2'b11) || (a == c);
  endfunction

  function automatic logic [7:0] model_stat();
    logic s;
    s = (m_pf && en_periodic) || (m_af && en_alarm) || (m_uf && en_update);
    return {s, m_pf, m_af, m_uf, 4'b0000};
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  // driver: apply one cycle, advance the model, queue the expected outcome
  task automatic cyc(input logic tk, input logic ud, input logic rd, input string req);
    logic hit;
    exp_t e;
    @(negedge clk);
    tick_periodic = tk; update_done = ud; stat_rd = rd;
    hit = fld_ok(alm_sec, cur_sec) && fld_ok(alm_min, cur_min) && fld_ok(alm_hr, cur_hr);
    @(posedge clk);
    m_pf = (m_pf && !rd) || tk;
    m_uf = (m_uf && !rd) || ud;
    m_af = (m_af && !rd) || (ud && hit);
    #1;
    e.st = model_stat(); e.irq = e.st[7]; e.req = req;
    exp_q.push_back(e);
    @(negedge clk);
    tick_periodic = 0; update_done = 0; stat_rd = 0;
  endtask

  // monitor: compare queued expectations after each edge
  initial begin
    forever begin
      @(posedge clk); #2;
      while (exp_q.size() > 0) begin
        exp_t e;
        e = exp_q.pop_front();
        check(e.req, stat_q, e.st);
        check({e.req, " irq"}, {7'b0, irq_o}, {7'b0, e.irq});
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 reset stat", stat_q, 8'h00);
    check("R1 reset irq", {7'b0, irq_o}, 8'h00);
    rst_n = 1;
    cur_sec = 8'h30; cur_min = 8'h15; cur_hr = 8'h09;
    alm_sec = 8'h31; alm_min = 8'h15; alm_hr = 8'h09;

    cyc(1, 0, 0, "R2 periodic sets bit6 with enable low");
    cyc(0, 0, 0, "R6 hold");
    cyc(0, 0, 0, "R6 hold again");
    en_periodic = 1; #1;
    check("R9 enable raises summary same cycle", stat_q, 8'hC0);
    cyc(0, 0, 1, "R7 read clears");
    cyc(0, 1, 0, "R3 update sets bit4, R4 seconds mismatch no alarm");
    cyc(0, 0, 1, "R7 read clears update");
    alm_sec = 8'h30; alm_min = 8'h16;
    cyc(0, 1, 1, "R4 minutes mismatch, R8 update with read");
    alm_min = 8'h15; alm_hr = 8'h10;
    cyc(0, 1, 1, "R4 hours mismatch");
    alm_hr = 8'h09;
    cyc(0, 0, 0, "R4 match without update_done ignored");
    cyc(0, 1, 1, "R4 full match sets alarm");
    en_alarm = 1;
    cyc(0, 0, 0, "R9 alarm enabled drives irq");
    cyc(0, 0, 1, "R7 read clears alarm");
    alm_sec = 8'hC0; cur_sec = 8'h47;
    cyc(0, 1, 1, "R5 wildcard seconds match");
    cyc(0, 0, 1, "R7 clear");
    alm_sec = 8'h80;
    cyc(0, 1, 0, "R5 top bit only is not wildcard");
    alm_sec = 8'hFF; alm_min = 8'hC5; alm_hr = 8'hD2;
    cyc(0, 1, 1, "R5 all wildcards");
    en_periodic = 0; en_alarm = 0; en_update = 1;
    cyc(1, 0, 1, "R8 tick with read survives");
    cyc(0, 0, 0, "R6 hold periodic");
    check("R10 low bits zero", {4'b0, stat_q[3:0]}, 8'h00);
    en_update = 0;
    cyc(0, 0, 1, "R7 final clear");
    repeat (3) @(posedge clk);
    finish_run();
  end
endmodule